// File: doc/BRIEF.md
# L1 Data Cache Snoop Responder

This block is the coherence-facing slice of a two-way set-associative write-back L1 data cache. It holds the tag, valid, dirty and replacement state for every set, and a line-wide data store. The next-level memory controller sends it snoop commands when DMA traffic touches next-level RAM. A snoop-read returns the addressed line so the DMA engine sees the newest data. A snoop-write merges up to one full line of new bytes into the cached copy, under a per-byte enable mask.

Snoops change line data in place. They never change the dirty, valid or replacement bits. A line that was dirty before a snoop is therefore still written back when a later CPU fill evicts it. A line that was clean stays clean, even after a snoop-write has changed its bytes.

A reduced CPU port exists so that this behaviour can be observed. It supports word reads, word stores and whole-line fills, and a fill reports any dirty victim on a writeback port. A snoop always takes priority over a CPU request in the same cycle.

Top module: `l1d_snoop_resp`

## Requirements
- R1: After reset every line is invalid, so snoops and CPU reads all miss, and the pulse outputs `snp_done`, `snp_rvalid`, `cpu_ack` and `wb_valid` are low.
- R2: A snoop-read that hits returns the whole 256-bit line on `snp_rdata` in the cycle after the command, with `snp_rvalid` and `snp_done` high.
- R3: A snoop-write that hits replaces only the bytes whose enable bit is set. Bit i of `snp_be` covers bits 8i+7..8i of `snp_wdata` and of the line. All other bytes keep their value.
- R4: A snoop, read or write, whose address matches no valid line completes the next cycle with `snp_done` and `snp_miss` high, `snp_rvalid` low and `snp_rdata` zero. It changes no data and allocates no line.
- R5: A snoop never changes a dirty bit. A dirty line that was snooped is written back with its merged contents when it is later evicted. A clean line that received a snoop-write produces no writeback on eviction.
- R6: A snoop never changes the replacement state or the valid bits, so the victim that a later fill chooses is the same as if the snoop had not happened.
- R7: When `snp_valid` and `cpu_req` are high in the same cycle, the snoop is served and `cpu_stall` is high in that cycle. The CPU request gets no `cpu_ack` for that cycle and is served in the next cycle if the requester holds it.
- R8: A CPU read (`cpu_op` = 0) acknowledges in the next cycle. On a hit, `cpu_hit` is high and `cpu_rdata` carries the word at bits 32w+31..32w of the line, where w = `cpu_addr[4:2]`. A read hit makes that way the most recently used.
- R9: A CPU store (`cpu_op` = 1) that hits writes `cpu_wdata` into word w and marks the line dirty. A store that misses changes nothing and reports `cpu_hit` low.
- R10: A CPU fill (`cpu_op` = 2) that misses installs `cpu_fill` as a clean line. It uses an invalid way first, way 0 before way 1, and otherwise the least recently used way. If that victim was valid and dirty, `wb_valid` pulses with the acknowledgement, together with the victim's line address and data. A fill that hits changes nothing. `cpu_op` = 3 is acknowledged with no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snp_valid | input | 1 | Snoop command present |
| snp_wr | input | 1 | 1 = snoop-write, 0 = snoop-read |
| snp_addr | input | ADDR_W | Snoop byte address |
| snp_wdata | input | 256 | Snoop-write line data |
| snp_be | input | 32 | Snoop-write byte enables |
| snp_done | output | 1 | Snoop completed (one cycle after command) |
| snp_miss | output | 1 | Completed snoop found no valid line |
| snp_rvalid | output | 1 | `snp_rdata` holds snoop-read hit data |
| snp_rdata | output | 256 | Snoop-read line data |
| cpu_req | input | 1 | CPU request present |
| cpu_op | input | 2 | 0 read, 1 store, 2 fill, 3 no-op |
| cpu_addr | input | ADDR_W | CPU byte address |
| cpu_wdata | input | 32 | Store data word |
| cpu_fill | input | 256 | Line data for a fill |
| cpu_stall | output | 1 | CPU request blocked this cycle by a snoop |
| cpu_ack | output | 1 | CPU request completed (one cycle after acceptance) |
| cpu_hit | output | 1 | Completed CPU request found its line |
| cpu_rdata | output | 32 | Read data word |
| wb_valid | output | 1 | Dirty victim written back |
| wb_addr | output | ADDR_W | Line address of the written-back victim |
| wb_data | output | 256 | Written-back line data |

## Verification
Every result is registered, so it is due exactly one clock edge after the edge that accepted the command: snoop completion and data, CPU acknowledgement and read word, and the writeback of a fill. The only exception is `cpu_stall`, which is combinational and is due in the same cycle as the colliding inputs. The bench drives inputs on the falling edge, waits for one rising edge, and samples all outputs on the following falling edge. It checks `cpu_stall` before that rising edge. Because snoops leave dirty and replacement state hidden, the bench makes it visible through the ports: later fills show which way is evicted and whether a writeback appears, and snoop-reads after those fills show which lines survived.

// File: rtl/l1d_snoop_resp.sv
module l1d_snoop_resp #(
  parameter int ADDR_W = 32,
  parameter int SETS   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                snp_valid,
  input  logic                snp_wr,
  input  logic [ADDR_W-1:0]   snp_addr,
  input  logic [255:0]        snp_wdata,
  input  logic [31:0]         snp_be,
  output logic                snp_done,
  output logic                snp_miss,
  output logic                snp_rvalid,
  output logic [255:0]        snp_rdata,
  input  logic                cpu_req,
  input  logic [1:0]          cpu_op,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic [31:0]         cpu_wdata,
  input  logic [255:0]        cpu_fill,
  output logic                cpu_stall,
  output logic                cpu_ack,
  output logic                cpu_hit,
  output logic [31:0]         cpu_rdata,
  output logic                wb_valid,
  output logic [ADDR_W-1:0]   wb_addr,
  output logic [255:0]        wb_data
);
  localparam int LINE_W = 256;
  localparam int BE_W   = LINE_W / 8;
  localparam int WRD_W  = 32;
  localparam int OFF_W  = $clog2(BE_W);
  localparam int WSEL_W = $clog2(LINE_W / WRD_W);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_FILL = 2'd2;

  logic [TAG_W-1:0]  tag_q  [SETS][2];
  logic [1:0]        vld_q  [SETS];
  logic [1:0]        dty_q  [SETS];
  logic              lru_q  [SETS];
  logic [LINE_W-1:0] data_q [SETS][2];

  wire [IDX_W-1:0]  s_idx  = snp_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0]  s_tag  = snp_addr[ADDR_W-1 -: TAG_W];
  wire [IDX_W-1:0]  c_idx  = cpu_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0]  c_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
  wire [WSEL_W-1:0] c_wsel = cpu_addr[2 +: WSEL_W];
  wire unused_addr_bits = ^{snp_addr[OFF_W-1:0], cpu_addr[1:0]};

  logic [1:0] s_hitv, c_hitv;
  always_comb begin
    for (int w = 0; w < 2; w++) begin
      s_hitv[w] = vld_q[s_idx][w] && (tag_q[s_idx][w] == s_tag);
      c_hitv[w] = vld_q[c_idx][w] && (tag_q[c_idx][w] == c_tag);
    end
  end

  wire s_hit  = |s_hitv;
  wire s_way  = s_hitv[1];
  wire c_hit  = |c_hitv;
  wire c_way  = c_hitv[1];
  wire c_vway = !vld_q[c_idx][0] ? 1'b0 :
                !vld_q[c_idx][1] ? 1'b1 : !lru_q[c_idx];
  wire cpu_go = cpu_req && !snp_valid;

  assign cpu_stall = cpu_req && snp_valid;

  logic [LINE_W-1:0] s_merged, c_merged;
  always_comb begin
    s_merged = data_q[s_idx][s_way];
    for (int b = 0; b < BE_W; b++)
      if (snp_be[b]) s_merged[b*8 +: 8] = snp_wdata[b*8 +: 8];
    c_merged = data_q[c_idx][c_way];
    c_merged[c_wsel*WRD_W +: WRD_W] = cpu_wdata;
  end

  always_ff @(posedge clk) begin
    if (snp_valid && snp_wr && s_hit)
      data_q[s_idx][s_way] <= s_merged;
    else if (cpu_go && cpu_op == OP_WR && c_hit)
      data_q[c_idx][c_way] <= c_merged;
    else if (cpu_go && cpu_op == OP_FILL && !c_hit)
      data_q[c_idx][c_vway] <= cpu_fill;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        dty_q[s] <= '0;
        lru_q[s] <= 1'b0;
        tag_q[s][0] <= '0;
        tag_q[s][1] <= '0;
      end
      snp_done <= 1'b0; snp_miss <= 1'b0; snp_rvalid <= 1'b0; snp_rdata <= '0;
      cpu_ack <= 1'b0; cpu_hit <= 1'b0; cpu_rdata <= '0;
      wb_valid <= 1'b0; wb_addr <= '0; wb_data <= '0;
    end else begin
      snp_done <= 1'b0; snp_miss <= 1'b0; snp_rvalid <= 1'b0; snp_rdata <= '0;
      cpu_ack <= 1'b0; cpu_hit <= 1'b0; cpu_rdata <= '0;
      wb_valid <= 1'b0; wb_addr <= '0; wb_data <= '0;
      if (snp_valid) begin
        snp_done   <= 1'b1;
        snp_miss   <= !s_hit;
        snp_rvalid <= !snp_wr && s_hit;
        if (!snp_wr && s_hit) snp_rdata <= data_q[s_idx][s_way];
      end else if (cpu_go) begin
        cpu_ack <= 1'b1;
        case (cpu_op)
          OP_RD: begin
            cpu_hit <= c_hit;
            if (c_hit) begin
              cpu_rdata     <= data_q[c_idx][c_way][c_wsel*WRD_W +: WRD_W];
              lru_q[c_idx]  <= c_way;
            end
          end
          OP_WR: begin
            cpu_hit <= c_hit;
            if (c_hit) begin
              dty_q[c_idx][c_way] <= 1'b1;
              lru_q[c_idx]        <= c_way;
            end
          end
          OP_FILL: begin
            cpu_hit <= c_hit;
            if (!c_hit) begin
              tag_q[c_idx][c_vway] <= c_tag;
              vld_q[c_idx][c_vway] <= 1'b1;
              dty_q[c_idx][c_vway] <= 1'b0;
              lru_q[c_idx]         <= c_vway;
              if (vld_q[c_idx][c_vway] && dty_q[c_idx][c_vway]) begin
                wb_valid <= 1'b1;
                wb_addr  <= {tag_q[c_idx][c_vway], c_idx, {OFF_W{1'b0}}};
                wb_data  <= data_q[c_idx][c_vway];
              end
            end
          end
          default: cpu_hit <= 1'b0;
        endcase
      end
    end
  end

  logic [2*SETS-1:0] dty_flat, vld_flat;
  logic [SETS-1:0]   lru_flat;
  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      dty_flat[2*s +: 2] = dty_q[s];
      vld_flat[2*s +: 2] = vld_q[s];
      lru_flat[s]        = lru_q[s];
    end
  end

  p_done_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |=> snp_done);
  p_rvalid_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    snp_rvalid |-> $past(snp_valid && !snp_wr));
  p_miss_no_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    snp_miss |-> (!snp_rvalid && snp_rdata == '0));
  p_keep_dirty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |=> $stable(dty_flat));
  p_keep_lru_r6: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |=> ($stable(lru_flat) && $stable(vld_flat)));
  p_one_way_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(s_hitv) && $onehot0(c_hitv));
  p_stall_no_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_stall |=> !cpu_ack);
  p_wb_with_fill_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (cpu_ack && $past(cpu_op == OP_FILL)));
endmodule

// File: tb/l1d_snoop_resp_bench.sv
module l1d_snoop_resp_bench;
  localparam int CLK_P = 10;
  localparam int SRD = 0, SWR = 1, CRD = 2, CWR = 3, FIL = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic snp_valid = 1'b0, snp_wr = 1'b0;
  logic [31:0] snp_addr = '0, snp_be = '0;
  logic [255:0] snp_wdata = '0;
  logic snp_done, snp_miss, snp_rvalid;
  logic [255:0] snp_rdata;
  logic cpu_req = 1'b0;
  logic [1:0] cpu_op = '0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [255:0] cpu_fill = '0;
  logic cpu_stall, cpu_ack, cpu_hit;
  logic [31:0] cpu_rdata;
  logic wb_valid;
  logic [31:0] wb_addr;
  logic [255:0] wb_data;
  int total = 0, bad = 0;

  always #(CLK_P/2) clk = ~clk;

  l1d_snoop_resp u_l1d_snoop_resp (
    .clk(clk), .rst_n(rst_n),
    .snp_valid(snp_valid), .snp_wr(snp_wr), .snp_addr(snp_addr),
    .snp_wdata(snp_wdata), .snp_be(snp_be),
    .snp_done(snp_done), .snp_miss(snp_miss), .snp_rvalid(snp_rvalid), .snp_rdata(snp_rdata),
    .cpu_req(cpu_req), .cpu_op(cpu_op), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_fill(cpu_fill),
    .cpu_stall(cpu_stall), .cpu_ack(cpu_ack), .cpu_hit(cpu_hit), .cpu_rdata(cpu_rdata),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data));

  typedef struct packed {
    logic [2:0]  kind;
    logic [31:0] addr;
    logic [7:0]  seed;
    logic [31:0] be;
    logic        hit;
    logic [7:0]  eseed;
    logic [31:0] eword;
    logic        wb;
    logic [31:0] wbaddr;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t TBL [NV] = '{
    '{3'd4, 32'h1000, 8'h01, 32'h0, 1'b0, 8'h00, 32'h0, 1'b0, 32'h0},
    '{3'd4, 32'h2000, 8'h02, 32'h0, 1'b0, 8'h00, 32'h0, 1'b0, 32'h0},
    '{3'd0, 32'h1000, 8'h00, 32'h0, 1'b1, 8'h01, 32'h0, 1'b0, 32'h0},
    '{3'd2, 32'h1008, 8'h00, 32'h0, 1'b1, 8'h01, 32'h0, 1'b0, 32'h0},
    '{3'd0, 32'h9000, 8'h00, 32'h0, 1'b0, 8'h00, 32'h0, 1'b0, 32'h0},
    '{3'd1, 32'h9000, 8'h05, 32'hFFFFFFFF, 1'b0, 8'h00, 32'h0, 1'b0, 32'h0},
    '{3'd0, 32'h9000, 8'h00, 32'h0, 1'b0, 8'h00, 32'h0, 1'b0, 32'h0},
    '{3'd4, 32'h1000, 8'h09, 32'h0, 1'b1, 8'h00, 32'h0, 1'b0, 32'h0},
    '{3'd0, 32'h1000, 8'h00, 32'h0, 1'b1, 8'h01, 32'h0, 1'b0, 32'h0},
    '{3'd3, 32'h2004, 8'h77, 32'h0, 1'b1, 8'h00, 32'h0, 1'b0, 32'h0},
    '{3'd2, 32'h2004, 8'h00, 32'h0, 1'b1, 8'h00, 32'h77777777, 1'b0, 32'h0},
    '{3'd3, 32'h9000, 8'h66, 32'h0, 1'b0, 8'h00, 32'h0, 1'b0, 32'h0},
    '{3'd4, 32'h3000, 8'h03, 32'h0, 1'b0, 8'h00, 32'h0, 1'b0, 32'h0},
    '{3'd4, 32'h1000, 8'h04, 32'h0, 1'b0, 8'h00, 32'h0, 1'b1, 32'h2000},
    '{3'd0, 32'h2000, 8'h00, 32'h0, 1'b0, 8'h00, 32'h0, 1'b0, 32'h0},
    '{3'd2, 32'h1000, 8'h00, 32'h0, 1'b1, 8'h04, 32'h0, 1'b0, 32'h0},
    '{3'd4, 32'h1020, 8'h06, 32'h0, 1'b0, 8'h00, 32'h0, 1'b0, 32'h0},
    '{3'd0, 32'h1020, 8'h00, 32'h0, 1'b1, 8'h06, 32'h0, 1'b0, 32'h0}
  };

  function automatic logic [255:0] line(input logic [7:0] s);
    logic [255:0] r;
    for (int w = 0; w < 8; w++) r[w*32 +: 32] = {s, 8'(w), s ^ 8'hA5, 8'(w*3)};
    return r;
  endfunction

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    snp_valid = 1'b0; snp_wr = 1'b0; snp_addr = '0; snp_wdata = '0; snp_be = '0;
    cpu_req = 1'b0; cpu_op = '0; cpu_addr = '0; cpu_wdata = '0; cpu_fill = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic op(input int kind, input logic [31:0] addr, input logic [7:0] seed,
                    input logic [31:0] be);
    @(negedge clk);
    idle();
    case (kind)
      SRD: begin snp_valid = 1'b1; snp_addr = addr; end
      SWR: begin snp_valid = 1'b1; snp_wr = 1'b1; snp_addr = addr;
                 snp_wdata = line(seed); snp_be = be; end
      CRD: begin cpu_req = 1'b1; cpu_op = 2'd0; cpu_addr = addr; end
      CWR: begin cpu_req = 1'b1; cpu_op = 2'd1; cpu_addr = addr; cpu_wdata = {4{seed}}; end
      default: begin cpu_req = 1'b1; cpu_op = 2'd2; cpu_addr = addr; cpu_fill = line(seed); end
    endcase
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not finish act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [255:0] tmp, expl;
    vec_t v;

    do_reset();
    // R1: reset state
    chk("R1 snp_done after reset", snp_done, 0);
    chk("R1 cpu_ack after reset", cpu_ack, 0);
    chk("R1 wb_valid after reset", wb_valid, 0);
    chk("R1 snp_rvalid after reset", snp_rvalid, 0);
    op(CRD, 32'h1000, 0, 0);
    chk("R1 cpu read misses", {cpu_ack, cpu_hit}, 2'b10);
    op(SRD, 32'h1000, 0, 0);
    chk("R1 snoop misses", {snp_done, snp_miss}, 2'b11);

    do_reset();
    for (int i = 0; i < NV; i++) begin
      v = TBL[i];
      op(int'(v.kind), v.addr, v.seed, v.be);
      if (v.kind == 3'd0 || v.kind == 3'd1) begin
        chk("R4 snoop done", snp_done, 1);
        chk("R4 snoop miss flag", snp_miss, !v.hit);
        if (v.kind == 3'd0 && v.hit) begin
          chk("R2 snoop-read valid", snp_rvalid, 1);
          chk("R2 snoop-read line", snp_rdata, line(v.eseed));
        end else begin
          chk("R4 no read data", {snp_rvalid, snp_rdata}, '0);
        end
      end else begin
        chk("R8 cpu ack", cpu_ack, 1);
        chk("R9 cpu hit flag", cpu_hit, v.hit);
        if (v.kind == 3'd2 && v.hit) begin
          tmp = line(v.eseed);
          chk("R8 cpu read word", cpu_rdata,
              (v.eseed != 0) ? 256'(tmp[v.addr[4:2]*32 +: 32]) : 256'(v.eword));
        end
        if (v.kind == 3'd4) begin
          chk("R10 writeback flag", wb_valid, v.wb);
          if (v.wb) chk("R10 writeback address", wb_addr, v.wbaddr);
        end
      end
    end

    // R3 and R5: byte-enable merge on a dirty line, then eviction
    do_reset();
    op(FIL, 32'h1000, 8'h01, 0);
    op(FIL, 32'h2000, 8'h02, 0);
    op(CWR, 32'h1000, 8'hDE, 0);
    op(CRD, 32'h2000, 0, 0);
    op(SWR, 32'h1000, 8'h50, 32'h000000F0);
    chk("R3 snoop-write hit", {snp_done, snp_miss, snp_rvalid}, 3'b100);
    expl = line(8'h01);
    expl[31:0] = 32'hDEDEDEDE;
    tmp = line(8'h50);
    for (int b = 4; b < 8; b++) expl[b*8 +: 8] = tmp[b*8 +: 8];
    op(SRD, 32'h1000, 0, 0);
    chk("R3 merged line", snp_rdata, expl);
    op(SWR, 32'h2000, 8'h60, 32'hFFFFFFFF);
    op(FIL, 32'h3000, 8'h03, 0);
    chk("R5 dirty snooped line written back", wb_valid, 1);
    chk("R5 writeback address", wb_addr, 32'h1000);
    chk("R5 writeback carries merged data", wb_data, expl);
    op(FIL, 32'h1000, 8'h04, 0);
    chk("R5 clean snoop-written line not written back", wb_valid, 0);
    op(SRD, 32'h2000, 0, 0);
    chk("R5 clean line evicted", snp_miss, 1);

    // R6: snoops leave replacement order alone
    do_reset();
    op(FIL, 32'h1000, 8'h11, 0);
    op(FIL, 32'h2000, 8'h12, 0);
    op(SRD, 32'h1000, 0, 0);
    op(SWR, 32'h1000, 8'h13, 32'h0000000F);
    op(FIL, 32'h3000, 8'h14, 0);
    op(SRD, 32'h1000, 0, 0);
    chk("R6 least recent way evicted despite snoops", snp_miss, 1);
    op(SRD, 32'h2000, 0, 0);
    chk("R6 recent way kept", {snp_rvalid, snp_rdata}, {1'b1, line(8'h12)});

    // R7: snoop and CPU collide
    do_reset();
    op(FIL, 32'h1000, 8'h21, 0);
    @(negedge clk);
    snp_valid = 1'b1; snp_addr = 32'h1000;
    cpu_req = 1'b1; cpu_op = 2'd0; cpu_addr = 32'h1004;
    #1;
    chk("R7 stall during collision", cpu_stall, 1);
    @(posedge clk);
    @(negedge clk);
    chk("R7 snoop served first", {snp_done, snp_rvalid}, 2'b11);
    chk("R7 cpu not acked", cpu_ack, 0);
    snp_valid = 1'b0;
    #1;
    chk("R7 stall released", cpu_stall, 0);
    @(posedge clk);
    @(negedge clk);
    tmp = line(8'h21);
    chk("R7 cpu served next cycle", {cpu_ack, cpu_hit, cpu_rdata}, {2'b11, tmp[63:32]});
    idle();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule